// File: doc/BRIEF.md
# Write-Drain Mode Controller

This block decides, channel by channel, when a memory controller stops serving reads and turns to draining its write queue, and when it returns. A channel switches into drain mode only when its write queue is completely full. At that moment the writes already queued are tagged in a per-entry mark vector. The channel stays in drain mode until enough of those tagged writes have been issued. Writes that arrive during the drain are not tagged, so a steady stream of new writes cannot hold the channel in drain mode.

Decisions are taken only on update steps, which the surrounding controller signals with `step_en`. Within one step, the exit test for a channel is evaluated before the entry test. A channel that leaves drain mode with a full queue therefore re-enters it in the same step, with a fresh set of marks.

Combinational helpers report, per channel, whether the write queue is empty or full and whether the read queue is empty. Two idle indications use per-core read-pending and low-intensity information, which a scheduler can use to issue writes opportunistically.

Top module: `wdrain_ctrl`

## Requirements
- R1: A channel not in drain mode enters it on an update step only when all DEPTH write-queue entries are valid. Seven of eight valid is not enough. Channels decide independently of each other.
- R2: On entry, the channel's mark vector becomes exactly the set of valid entries, and `mark_set` pulses for one cycle. Outside drain mode the mark vector is all zero.
- R3: A mark is dropped in the cycle after its entry's valid bit goes low. An entry that becomes valid during drain mode is not marked.
- R4: The threshold is THR = floor((DRAIN_DEN-DRAIN_NUM)*DEPTH/DRAIN_DEN), which is 4 with the defaults (DEPTH 8, fraction 1/2). The channel stays in drain mode on a step while more than THR valid entries are marked.
- R5: On a step where the marked count is at or below THR, the channel leaves drain mode, clears all of its marks and pulses `mark_clr`.
- R6: The exit test runs before the entry test. If a channel exits on a step while its queue is full, it ends that step in drain mode, `mark_clr` and `mark_set` both pulse, and the marks equal the valid entries.
- R7: With `step_en` low, neither the mode nor the pulses change. `step_count` increases by one on every cycle with `step_en` high.
- R8: `wq_empty` is high when no entry is valid. `wq_full` is high when all entries are valid. `rq_empty` is high when the channel's read load is zero.
- R9: `rq_idle` is high only when `intens_valid` is 1, at least one core is flagged in `lowint_mask`, and no flagged core has a pending read on the channel. `wq_idle` additionally requires the valid count times 4 to be at least DEPTH.
- R10: After reset, every channel is out of drain mode, all marks are zero, the pulses are low and `step_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_en | input | 1 | Update step strobe |
| wq_valid | input | NCH*DEPTH | Per-entry write-queue valid, per channel |
| rd_load | input | NCH*RLW | Read-queue occupancy per channel |
| lowint_mask | input | NCORE | Cores flagged as low memory intensity |
| lowint_pend | input | NCH*NCORE | Per channel, per core: a read is pending |
| intens_valid | input | 1 | Intensity classification is valid |
| wr_mode | output | NCH | Drain mode flag per channel |
| mark_set | output | NCH | One-cycle pulse: entries were marked |
| mark_clr | output | NCH | One-cycle pulse: marks were cleared |
| wq_marks | output | NCH*DEPTH | Current per-entry mark vector |
| wq_empty | output | NCH | Write queue empty |
| wq_full | output | NCH | Write queue full |
| rq_empty | output | NCH | Read queue empty |
| wq_idle | output | NCH | Idle with write queue at least a quarter full |
| rq_idle | output | NCH | No flagged core has a read pending |
| step_count | output | CW | Update step counter |

## Verification
Exit and re-entry can fall on the same update step. To provoke this, a channel is filled and marked, then exactly THR marked entries are kept while the rest are retired. The freed slots are refilled with unmarked writes, so the queue is full again when the next step arrives. The bench expects the channel to stay in drain mode, both pulses to appear in the same cycle, and the mark vector to cover every entry, including the refilled ones. A separate case leaves the queue short of full on the exit step and expects a plain exit.

// File: rtl/wdrain_pkg.sv
package wdrain_pkg;
    function automatic int drain_thresh(input int depth, input int num, input int den);
        return ((den - num) * depth) / den;
    endfunction
endpackage

// File: rtl/wdrain_chan.sv
module wdrain_chan #(
    parameter int DEPTH     = 8,
    parameter int DRAIN_NUM = 1,
    parameter int DRAIN_DEN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_en,
    input  logic [DEPTH-1:0] valid,
    output logic             mode,
    output logic             mark_set,
    output logic             mark_clr,
    output logic [DEPTH-1:0] marks
);
    localparam int THR = wdrain_pkg::drain_thresh(DEPTH, DRAIN_NUM, DRAIN_DEN);

    typedef struct packed {
        logic             mode;
        logic [DEPTH-1:0] marks;
        logic             set;
        logic             clr;
    } chan_st_t;

    chan_st_t st_q, st_d;
    logic     mode_mid;
    logic     full;
    int       marked_cnt;

    assign full       = &valid;
    assign marked_cnt = int'($countones(st_q.marks & valid));

    always_comb begin
        st_d       = st_q;
        st_d.set   = 1'b0;
        st_d.clr   = 1'b0;
        st_d.marks = st_q.marks & valid;
        mode_mid   = st_q.mode;
        if (step_en) begin
            if (st_q.mode && (marked_cnt <= THR)) begin
                st_d.marks = '0;
                st_d.clr   = 1'b1;
                mode_mid   = 1'b0;
            end
            if (!mode_mid && full) begin
                st_d.marks = valid;
                st_d.set   = 1'b1;
                mode_mid   = 1'b1;
            end
            st_d.mode = mode_mid;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode     = st_q.mode;
    assign mark_set = st_q.set;
    assign mark_clr = st_q.clr;
    assign marks    = st_q.marks;

    a_r2_unmarked_outside: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.mode |-> (st_q.marks == '0));
    a_r1_enter_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.mode && !(&valid)) |=> !st_q.mode);
    a_r7_hold_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> ($stable(st_q.mode) && !st_q.set && !st_q.clr));
    a_r3_marks_follow_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && st_q.mode) |=> ((st_q.marks & ~$past(valid)) == '0));
    a_r6_set_means_mode: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.set |-> st_q.mode);
endmodule

// File: rtl/wdrain_status.sv
module wdrain_status #(
    parameter int DEPTH = 8,
    parameter int RLW   = 4,
    parameter int NCORE = 4
) (
    input  logic [DEPTH-1:0] valid,
    input  logic [RLW-1:0]   rd_load,
    input  logic [NCORE-1:0] lowint_mask,
    input  logic [NCORE-1:0] lowint_pend,
    input  logic             intens_valid,
    output logic             wq_empty,
    output logic             wq_full,
    output logic             rq_empty,
    output logic             wq_idle,
    output logic             rq_idle
);
    int  occ;
    logic rd_quiet;

    assign occ      = int'($countones(valid));
    assign wq_empty = (valid == '0);
    assign wq_full  = &valid;
    assign rq_empty = (rd_load == '0);
    assign rd_quiet = intens_valid && (lowint_mask != '0) && ((lowint_mask & lowint_pend) == '0);
    assign rq_idle  = rd_quiet;
    assign wq_idle  = rd_quiet && (occ * 4 >= DEPTH);

    always_comb begin
        a_r8_empty_full_excl: assert (!(wq_empty && wq_full));
        a_r9_idle_implies_rq: assert (!wq_idle || rq_idle);
    end
endmodule

// File: rtl/wdrain_ctrl.sv
module wdrain_ctrl #(
    parameter int NCH       = 2,
    parameter int DEPTH     = 8,
    parameter int DRAIN_NUM = 1,
    parameter int DRAIN_DEN = 2,
    parameter int RLW       = 4,
    parameter int NCORE     = 4,
    parameter int CW        = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step_en,
    input  logic [NCH-1:0][DEPTH-1:0]  wq_valid,
    input  logic [NCH-1:0][RLW-1:0]    rd_load,
    input  logic [NCORE-1:0]           lowint_mask,
    input  logic [NCH-1:0][NCORE-1:0]  lowint_pend,
    input  logic                       intens_valid,
    output logic [NCH-1:0]             wr_mode,
    output logic [NCH-1:0]             mark_set,
    output logic [NCH-1:0]             mark_clr,
    output logic [NCH-1:0][DEPTH-1:0]  wq_marks,
    output logic [NCH-1:0]             wq_empty,
    output logic [NCH-1:0]             wq_full,
    output logic [NCH-1:0]             rq_empty,
    output logic [NCH-1:0]             wq_idle,
    output logic [NCH-1:0]             rq_idle,
    output logic [CW-1:0]              step_count
);
    typedef struct packed {
        logic [CW-1:0] cnt;
    } top_st_t;

    top_st_t top_q, top_d;

    always_comb begin
        top_d = top_q;
        if (step_en) top_d.cnt = top_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign step_count = top_q.cnt;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        wdrain_chan #(
            .DEPTH(DEPTH), .DRAIN_NUM(DRAIN_NUM), .DRAIN_DEN(DRAIN_DEN)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .step_en(step_en),
            .valid(wq_valid[c]), .mode(wr_mode[c]),
            .mark_set(mark_set[c]), .mark_clr(mark_clr[c]), .marks(wq_marks[c])
        );
        wdrain_status #(
            .DEPTH(DEPTH), .RLW(RLW), .NCORE(NCORE)
        ) u_stat (
            .valid(wq_valid[c]), .rd_load(rd_load[c]),
            .lowint_mask(lowint_mask), .lowint_pend(lowint_pend[c]),
            .intens_valid(intens_valid),
            .wq_empty(wq_empty[c]), .wq_full(wq_full[c]), .rq_empty(rq_empty[c]),
            .wq_idle(wq_idle[c]), .rq_idle(rq_idle[c])
        );
    end

    a_r7_step_counts: assert property (@(posedge clk) disable iff (!rst_n)
        step_en |=> (step_count == CW'($past(step_count) + 1'b1)));
    a_r7_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !step_en |=> $stable(step_count));
endmodule

// File: tb/tb_wdrain_ctrl.sv
module tb_wdrain_ctrl;
    localparam int NCH = 2, DEPTH = 8, RLW = 4, NCORE = 4, CW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_en = 1'b0;
    logic [NCH-1:0][DEPTH-1:0] wq_valid = '0;
    logic [NCH-1:0][RLW-1:0]   rd_load = '0;
    logic [NCORE-1:0]          lowint_mask = '0;
    logic [NCH-1:0][NCORE-1:0] lowint_pend = '0;
    logic                      intens_valid = 1'b0;
    logic [NCH-1:0] wr_mode, mark_set, mark_clr, wq_empty, wq_full, rq_empty, wq_idle, rq_idle;
    logic [NCH-1:0][DEPTH-1:0] wq_marks;
    logic [CW-1:0] step_count;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wdrain_ctrl dut (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .wq_valid(wq_valid),
        .rd_load(rd_load), .lowint_mask(lowint_mask), .lowint_pend(lowint_pend),
        .intens_valid(intens_valid), .wr_mode(wr_mode), .mark_set(mark_set),
        .mark_clr(mark_clr), .wq_marks(wq_marks), .wq_empty(wq_empty),
        .wq_full(wq_full), .rq_empty(rq_empty), .wq_idle(wq_idle),
        .rq_idle(rq_idle), .step_count(step_count)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic step();
        step_en = 1'b1;
        @(posedge clk); @(negedge clk);
        step_en = 1'b0;
    endtask

    task automatic idle_cyc();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; wq_valid = '0;
        idle_cyc(); idle_cyc();
        rst_n = 1'b1;
        chk("R10 mode", 32'(wr_mode), 0);
        chk("R10 marks", 32'(wq_marks), 0);
        chk("R10 pulses", 32'({mark_set, mark_clr}), 0);
        chk("R10 count", 32'(step_count), 0);
    endtask

    task automatic t_partial_no_enter();
        wq_valid[0] = 8'h7F;
        step();
        chk("R1 seven of eight no entry", 32'(wr_mode[0]), 0);
        chk("R7 count one step", 32'(step_count), 1);
    endtask

    task automatic t_no_step_full();
        wq_valid[0] = 8'hFF;
        idle_cyc(); idle_cyc();
        chk("R7 full without step holds", 32'(wr_mode[0]), 0);
        chk("R7 count unchanged", 32'(step_count), 1);
    endtask

    task automatic t_enter();
        step();
        chk("R1 enter on full", 32'(wr_mode), 32'b01);
        chk("R2 marks all", 32'(wq_marks[0]), 32'hFF);
        chk("R2 set pulse", 32'(mark_set), 32'b01);
        idle_cyc();
        chk("R2 set pulse one cycle", 32'(mark_set), 0);
        chk("R1 other channel idle", 32'(wq_marks[1]), 0);
    endtask

    task automatic t_drain_stay_exit();
        wq_valid[0] = 8'hF8;
        idle_cyc();
        chk("R3 marks drop with valid", 32'(wq_marks[0]), 32'hF8);
        wq_valid[0] = 8'hF9;
        idle_cyc();
        chk("R3 new entry unmarked", 32'(wq_marks[0]), 32'hF8);
        step();
        chk("R4 stay with 5 marked", 32'(wr_mode[0]), 1);
        chk("R4 no clear pulse", 32'(mark_clr[0]), 0);
        wq_valid[0] = 8'hF1;
        idle_cyc();
        step();
        chk("R5 exit at 4 marked", 32'(wr_mode[0]), 0);
        chk("R5 marks cleared", 32'(wq_marks[0]), 0);
        chk("R5 clr pulse", 32'(mark_clr[0]), 1);
        chk("R5 no set pulse", 32'(mark_set[0]), 0);
    endtask

    task automatic t_reentry();
        wq_valid[0] = 8'hFF;
        step();
        chk("R1 reenter full", 32'(wr_mode[0]), 1);
        wq_valid[0] = 8'hF0;
        idle_cyc();
        wq_valid[0] = 8'hFF;
        idle_cyc();
        chk("R3 refilled unmarked", 32'(wq_marks[0]), 32'hF0);
        step();
        chk("R6 still in mode", 32'(wr_mode[0]), 1);
        chk("R6 both pulses", 32'({mark_set[0], mark_clr[0]}), 32'b11);
        chk("R6 marks all valid", 32'(wq_marks[0]), 32'hFF);
    endtask

    task automatic t_chan_indep();
        wq_valid[1] = 8'hFF;
        wq_valid[0] = 8'h00;
        step();
        chk("R1 ch1 enters", 32'(wr_mode[1]), 1);
        chk("R5 ch0 exits empty", 32'(wr_mode[0]), 0);
        chk("R2 ch1 marks", 32'(wq_marks[1]), 32'hFF);
    endtask

    task automatic t_status();
        wq_valid = '0; rd_load = '0;
        #1;
        chk("R8 empty", 32'(wq_empty), 32'b11);
        chk("R8 rq empty", 32'(rq_empty), 32'b11);
        wq_valid[1] = 8'hFF; rd_load[0] = 4'd3;
        #1;
        chk("R8 full", 32'(wq_full), 32'b10);
        chk("R8 rq nonempty", 32'(rq_empty), 32'b10);
        chk("R8 not empty", 32'(wq_empty), 32'b01);
    endtask

    task automatic t_idle();
        wq_valid[0] = 8'h03; intens_valid = 1'b1; lowint_mask = 4'b0001; lowint_pend = '0;
        #1;
        chk("R9 quarter full idle", 32'(wq_idle[0]), 1);
        chk("R9 rq idle", 32'(rq_idle[0]), 1);
        wq_valid[0] = 8'h01;
        #1;
        chk("R9 below quarter", 32'({wq_idle[0], rq_idle[0]}), 32'b01);
        wq_valid[0] = 8'h0F; lowint_pend[0] = 4'b0010;
        #1;
        chk("R9 other core pend ignored", 32'(wq_idle[0]), 1);
        lowint_pend[0] = 4'b0001;
        #1;
        chk("R9 low core pending", 32'({wq_idle[0], rq_idle[0]}), 0);
        lowint_pend[0] = '0; lowint_mask = '0;
        #1;
        chk("R9 no low core", 32'(rq_idle[0]), 0);
        lowint_mask = 4'b0001; intens_valid = 1'b0;
        #1;
        chk("R9 not valid", 32'(rq_idle[0]), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_partial_no_enter();
        t_no_step_full();
        t_enter();
        t_drain_stay_exit();
        t_reentry();
        t_chan_indep();
        t_status();
        t_idle();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog got=hung exp=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule